// File: doc/BRIEF.md
# Paired Double-Buffered Bulk IN Endpoint Controller

This block keeps track of the packet buffers behind two neighbouring bulk IN endpoints, an even one and an odd one. In unpaired mode, each endpoint owns one buffer. Loading an endpoint's byte count arms that buffer, and a successful transmission frees it again. When pairing is switched on, the two buffers become a single double-buffered endpoint. Software then works only with the even endpoint's configuration and byte-count registers. Each byte-count load fills whichever buffer is next free, and the buffers leave in the order they were armed.

A simple register port is used to write the registers. The pairing register, the two configuration registers (valid and interrupt enable) and the two byte-count registers can be written. There are also write-one strobes that clear busy, the interrupt requests and the overrun flags. The block shows the current request to a transmit engine: which buffer and how many bytes. A buffer counts as sent only when the engine returns a one-cycle success pulse. Each success raises a sticky interrupt request, and whether busy changes has no bearing on this.

Top module: `dbl_in_endpoint`

## Requirements
- R1: Register addresses are 0 pairing (bit 0 is the enable), 1 even config, 2 odd config (in both config registers bit 0 is valid and bit 1 is interrupt enable), 3 even byte count, 4 odd byte count, 5 busy clear, 6 interrupt clear and 7 overrun clear. In the three clear registers bit 0 selects even and bit 1 selects odd. While pairing is on, writes to address 2 and address 4 leave busy, overrun and the transmit request unchanged.
- R2: While paired, each accepted even byte-count write marks the next free buffer full. The fill position alternates between buffer 0 and buffer 1, and the written value becomes that buffer's length.
- R3: While paired, busy_even is 1 exactly when both buffers are full, and busy_odd stays 0.
- R4: While paired, buffers are offered in the order they were armed. tx_buf alternates 0, 1, 0, ..., and tx_len equals the length written for that buffer.
- R5: A buffer is freed only by tx_ok while tx_req is high. Cycles without tx_ok (NAK or retry) keep tx_req, tx_buf and tx_len unchanged.
- R6: Every sent packet sets the interrupt flag of its endpoint if that endpoint's interrupt enable is set. This happens whether busy changes or not. A 1 written to the matching bit at address 6 clears the flag. While paired, sent packets belong to the even endpoint.
- R7: A byte-count write to an endpoint whose buffers are all full is dropped and sets that endpoint's sticky overrun flag. Writing a 1 to the matching bit at address 7 clears the flag.
- R8: While paired, a busy-clear write with bit 0 set empties both buffers and returns both pointers to buffer 0.
- R9: While unpaired, each endpoint has one buffer (even is buffer 0, odd is buffer 1). Its busy bit is set by its own byte-count write and cleared when that packet is sent. The even buffer goes first when both are ready.
- R10: A full buffer is not requested while the endpoint that owns it is not valid.
- R11: Any write to the pairing register empties both buffers and resets both pointers.
- R12: All register and flag outputs change at the clock edge that samples the write or tx_ok. The transmit request follows from that state in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | ADDR_W | Register address |
| cpu_wdata | input | LEN_W | Write data (byte count or control bits) |
| tx_ok | input | 1 | One-cycle success pulse for the request shown |
| tx_req | output | 1 | A buffer is ready to send |
| tx_buf | output | 1 | Index of the buffer being offered |
| tx_len | output | LEN_W | Byte count of the buffer being offered |
| busy_even | output | 1 | Even endpoint busy |
| busy_odd | output | 1 | Odd endpoint busy |
| irq_even | output | 1 | Even endpoint interrupt request |
| irq_odd | output | 1 | Odd endpoint interrupt request |
| ovr_even | output | 1 | Even endpoint overrun flag |
| ovr_odd | output | 1 | Odd endpoint overrun flag |

## Verification
A register write or tx_ok pulse is driven for exactly one clock. Busy, overrun and interrupt outputs are registered, so they take their new values at that same rising edge. tx_req, tx_buf and tx_len are derived from that registered state, so they are also settled before the next edge. The bench drives every input on the falling edge and samples on the following falling edge. That point lies after the edge that applied the stimulus and before the next one. The bench steps through zero to three byte-count loads on a paired endpoint while the pointer state carries over from one round to the next, and it checks the drain order against an arithmetic model of the two slots.

// File: rtl/pie_pkg.sv
package pie_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_PAIR     = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG_EVEN = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFG_ODD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_BC_EVEN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_BC_ODD   = 3'd4;
  localparam logic [ADDR_W-1:0] A_BUSY_CLR = 3'd5;
  localparam logic [ADDR_W-1:0] A_IRQ_CLR  = 3'd6;
  localparam logic [ADDR_W-1:0] A_OVR_CLR  = 3'd7;
  localparam int NUM_EP = 2;
endpackage

// File: rtl/pie_cfg_regs.sv
module pie_cfg_regs
  import pie_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wbits,
  output logic              pair_en,
  output logic [NUM_EP-1:0] valid,
  output logic [NUM_EP-1:0] ie
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pair_en <= 1'b0;
      valid   <= '0;
      ie      <= '0;
    end else if (wr) begin
      if (addr == A_PAIR) pair_en <= wbits[0];
      if (addr == A_CFG_EVEN) begin
        valid[0] <= wbits[0];
        ie[0]    <= wbits[1];
      end
      // odd configuration is frozen while the pair is formed
      if (addr == A_CFG_ODD && !pair_en) begin
        valid[1] <= wbits[0];
        ie[1]    <= wbits[1];
      end
    end
  end
endmodule

// File: rtl/pie_slot_ctrl.sv
module pie_slot_ctrl
  import pie_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pair_en,
  input  logic [NUM_EP-1:0] valid,
  input  logic [NUM_EP-1:0] bc_wr,
  input  logic [LEN_W-1:0]  bc_val,
  input  logic [NUM_EP-1:0] bclr,
  input  logic [NUM_EP-1:0] oclr,
  input  logic              flush,
  input  logic              tx_ok,
  output logic              tx_req,
  output logic              tx_buf,
  output logic [LEN_W-1:0]  tx_len,
  output logic [NUM_EP-1:0] sent,
  output logic [NUM_EP-1:0] busy,
  output logic [NUM_EP-1:0] ovr
);
  logic [NUM_EP-1:0] full_q, full_n;
  logic [NUM_EP-1:0] ovr_n;
  logic              fp_q, fp_n, sp_q, sp_n;
  logic              mem_we, mem_wa;
  logic [LEN_W-1:0]  len_mem [NUM_EP];
  logic              done;

  // request selection from registered slot state
  always_comb begin
    if (pair_en) begin
      tx_req = valid[0] & full_q[sp_q];
      tx_buf = sp_q;
    end else begin
      tx_req = (valid[0] & full_q[0]) | (valid[1] & full_q[1]);
      tx_buf = !(valid[0] & full_q[0]);
    end
  end
  assign tx_len = len_mem[tx_buf];
  assign done   = tx_ok & tx_req;

  always_comb begin
    sent = '0;
    if (done) sent[pair_en ? 1'b0 : tx_buf] = 1'b1;
  end

  always_comb begin
    full_n = full_q;
    fp_n   = fp_q;
    sp_n   = sp_q;
    ovr_n  = ovr & ~oclr;
    mem_we = 1'b0;
    mem_wa = 1'b0;
    if (done) begin
      full_n[tx_buf] = 1'b0;
      if (pair_en) sp_n = ~sp_q;
    end
    if (pair_en) begin
      if (bc_wr[0]) begin
        if (&full_q) ovr_n[0] = 1'b1;
        else begin
          full_n[fp_q] = 1'b1;
          mem_we = 1'b1;
          mem_wa = fp_q;
          fp_n   = ~fp_q;
        end
      end
      if (bclr[0]) begin
        full_n = '0;
        fp_n   = 1'b0;
        sp_n   = 1'b0;
      end
    end else begin
      for (int i = 0; i < NUM_EP; i++) begin
        if (bc_wr[i]) begin
          if (full_q[i]) ovr_n[i] = 1'b1;
          else begin
            full_n[i] = 1'b1;
            mem_we = 1'b1;
            mem_wa = i[0];
          end
        end
        if (bclr[i]) full_n[i] = 1'b0;
      end
    end
    if (flush) begin
      full_n = '0;
      fp_n   = 1'b0;
      sp_n   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= '0;
      fp_q   <= 1'b0;
      sp_q   <= 1'b0;
      ovr    <= '0;
    end else begin
      full_q <= full_n;
      fp_q   <= fp_n;
      sp_q   <= sp_n;
      ovr    <= ovr_n;
    end
  end

  // length store, no reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (mem_we && !flush) len_mem[mem_wa] <= bc_val;
  end

  assign busy = pair_en ? {1'b0, &full_q} : full_q;
endmodule

// File: rtl/pie_irq_flags.sv
module pie_irq_flags
  import pie_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EP-1:0] sent,
  input  logic [NUM_EP-1:0] ie,
  input  logic [NUM_EP-1:0] iclr,
  output logic [NUM_EP-1:0] irq
);
  for (genvar g = 0; g < NUM_EP; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) irq[g] <= 1'b0;
      else if (sent[g] && ie[g]) irq[g] <= 1'b1;
      else if (iclr[g]) irq[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/dbl_in_endpoint.sv
module dbl_in_endpoint
  import pie_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [LEN_W-1:0]  cpu_wdata,
  input  logic              tx_ok,
  output logic              tx_req,
  output logic              tx_buf,
  output logic [LEN_W-1:0]  tx_len,
  output logic              busy_even,
  output logic              busy_odd,
  output logic              irq_even,
  output logic              irq_odd,
  output logic              ovr_even,
  output logic              ovr_odd
);
  logic              pair_en;
  logic [NUM_EP-1:0] valid, ie, bc_wr, bclr, iclr, oclr, sent, busy, irq, ovr;
  logic              flush;

  function automatic logic [NUM_EP-1:0] strobe(input logic [ADDR_W-1:0] a);
    return (cpu_wr && cpu_addr == a) ? cpu_wdata[NUM_EP-1:0] : '0;
  endfunction

  assign flush    = cpu_wr && cpu_addr == A_PAIR;
  assign bc_wr[0] = cpu_wr && cpu_addr == A_BC_EVEN;
  assign bc_wr[1] = cpu_wr && cpu_addr == A_BC_ODD && !pair_en;
  assign bclr     = strobe(A_BUSY_CLR);
  assign iclr     = strobe(A_IRQ_CLR);
  assign oclr     = strobe(A_OVR_CLR);

  pie_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .wr(cpu_wr), .addr(cpu_addr), .wbits(cpu_wdata[1:0]),
    .pair_en(pair_en), .valid(valid), .ie(ie)
  );

  pie_slot_ctrl #(.LEN_W(LEN_W)) u_slots (
    .clk(clk), .rst(rst), .pair_en(pair_en), .valid(valid), .bc_wr(bc_wr),
    .bc_val(cpu_wdata), .bclr(bclr), .oclr(oclr), .flush(flush), .tx_ok(tx_ok),
    .tx_req(tx_req), .tx_buf(tx_buf), .tx_len(tx_len), .sent(sent),
    .busy(busy), .ovr(ovr)
  );

  pie_irq_flags u_irq (
    .clk(clk), .rst(rst), .sent(sent), .ie(ie), .iclr(iclr), .irq(irq)
  );

  assign busy_even = busy[0];
  assign busy_odd  = busy[1];
  assign irq_even  = irq[0];
  assign irq_odd   = irq[1];
  assign ovr_even  = ovr[0];
  assign ovr_odd   = ovr[1];
endmodule

// File: rtl/pie_checker.sv
module pie_checker
  import pie_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              pair_en,
  input logic [NUM_EP-1:0] valid,
  input logic [NUM_EP-1:0] ie,
  input logic              cpu_wr,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [LEN_W-1:0]  cpu_wdata,
  input logic              tx_ok,
  input logic              tx_req,
  input logic              tx_buf,
  input logic [LEN_W-1:0]  tx_len,
  input logic              busy_odd,
  input logic              busy_even,
  input logic              irq_even,
  input logic              ovr_even
);
  assert_odd_idle_R3: assert property (@(posedge clk) disable iff (rst)
    pair_en |-> !busy_odd);

  assert_hold_on_nak_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_ok && !cpu_wr) |=> (tx_req && $stable(tx_buf) && $stable(tx_len)));

  assert_irq_after_send_R6: assert property (@(posedge clk) disable iff (rst)
    (pair_en && tx_req && tx_ok && ie[0] && !cpu_wr) |=> irq_even);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (ovr_even && !(cpu_wr && cpu_addr == A_OVR_CLR)) |=> ovr_even);

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
    (pair_en && cpu_wr && cpu_addr == A_BUSY_CLR && cpu_wdata[0]) |=> (!busy_even && !tx_req));

  assert_valid_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (valid == '0) |-> !tx_req);
endmodule

bind dbl_in_endpoint pie_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .pair_en(pair_en), .valid(valid), .ie(ie),
  .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .tx_ok(tx_ok),
  .tx_req(tx_req), .tx_buf(tx_buf), .tx_len(tx_len), .busy_odd(busy_odd),
  .busy_even(busy_even), .irq_even(irq_even), .ovr_even(ovr_even)
);

// File: tb/dbl_in_endpoint_bench.sv
`timescale 1ns/1ps
module dbl_in_endpoint_bench;
  localparam int LW = 7;
  logic clk = 1'b0, rst = 1'b1;
  logic cpu_wr = 1'b0, tx_ok = 1'b0;
  logic [2:0] cpu_addr = '0;
  logic [LW-1:0] cpu_wdata = '0;
  logic tx_req, tx_buf, busy_even, busy_odd, irq_even, irq_odd, ovr_even, ovr_odd;
  logic [LW-1:0] tx_len;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbl_in_endpoint #(.LEN_W(LW)) u_dbl_in_endpoint (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .tx_ok(tx_ok), .tx_req(tx_req), .tx_buf(tx_buf), .tx_len(tx_len),
    .busy_even(busy_even), .busy_odd(busy_odd), .irq_even(irq_even), .irq_odd(irq_odd),
    .ovr_even(ovr_even), .ovr_odd(ovr_odd)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); cpu_wr = 1'b1; cpu_addr = a[2:0]; cpu_wdata = d[LW-1:0];
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic send_ok();
    @(negedge clk); tx_ok = 1'b1;
    @(negedge clk); tx_ok = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int slot_len[2];
    int cnt, fp, sp, ln;
    bit ovr_exp;
    idle(3); rst = 1'b0; idle(1);
    chk("reset tx_req R12", tx_req, 0);
    chk("reset busy R3", busy_even, 0);
    chk("reset irq R6", irq_even, 0);

    // paired sweep: R2 R3 R4 R5 R6 R7
    wr(1, 3); wr(0, 1);
    cnt = 0; fp = 0; sp = 0;
    for (int n = 0; n < 4; n++) begin
      ovr_exp = 0;
      for (int k = 0; k < n; k++) begin
        ln = 3 + 7 * n + k;
        wr(3, ln);
        if (cnt == 2) ovr_exp = 1;
        else begin slot_len[fp] = ln; fp ^= 1; cnt++; end
        chk("busy after load R3", busy_even, cnt == 2);
        chk("odd busy paired R3", busy_odd, 0);
      end
      chk("overrun flag R7", ovr_even, ovr_exp);
      wr(7, 1);
      chk("overrun cleared R7", ovr_even, 0);
      while (cnt > 0) begin
        idle(2);
        chk("held without ok R5", tx_req, 1);
        chk("buffer order R4", tx_buf, sp);
        chk("length R2 R4", tx_len, slot_len[sp]);
        send_ok();
        cnt--; sp ^= 1;
        chk("irq on send R6", irq_even, 1);
        chk("busy after send R3", busy_even, 0);
        wr(6, 1);
        chk("irq cleared R6", irq_even, 0);
      end
      chk("drained R5", tx_req, 0);
    end

    // odd registers ignored while paired R1
    wr(4, 9); wr(2, 3);
    chk("odd bc ignored R1", tx_req, 0);
    chk("odd busy ignored R1", busy_odd, 0);
    chk("odd overrun ignored R1", ovr_odd, 0);

    // busy-clear procedure R8
    wr(3, 11); wr(3, 12);
    chk("both full R8", busy_even, 1);
    wr(5, 3);
    chk("busy cleared R8", busy_even, 0);
    chk("no request after clear R8", tx_req, 0);
    wr(3, 13);
    chk("pointer reset R8", tx_buf, 0);
    chk("len after clear R8", tx_len, 13);

    // valid gating R10
    wr(1, 2);
    chk("invalid no request R10", tx_req, 0);
    wr(1, 3);
    chk("valid request R10", tx_req, 1);

    // pairing write flushes R11
    wr(0, 0);
    chk("flush request R11", tx_req, 0);
    chk("flush busy R11", busy_even, 0);

    // unpaired mode R9 (odd cfg: valid, no irq)
    wr(2, 1);
    wr(4, 21);
    chk("odd busy set R9", busy_odd, 1);
    chk("even busy clear R9", busy_even, 0);
    chk("odd offered R9", tx_buf, 1);
    wr(3, 22);
    chk("even priority R9", tx_buf, 0);
    chk("even len R9", tx_len, 22);
    wr(3, 23);
    chk("unpaired overrun R7", ovr_even, 1);
    send_ok();
    chk("even sent irq R6", irq_even, 1);
    chk("even busy cleared R9", busy_even, 0);
    chk("odd next R9", tx_buf, 1);
    chk("odd len R9", tx_len, 21);
    send_ok();
    chk("odd busy cleared R9", busy_odd, 0);
    chk("odd irq gated R6", irq_odd, 0);
    chk("unpaired idle R12", tx_req, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule